// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small programmable logic device built from ordinary synthesizable logic. A bank of data inputs feeds an AND plane. Each product term in that plane can take any input in true form, in complemented form, or not at all. Every output ORs together its own fixed group of product terms, and the group size grows from one output to the next. A per-output cell then passes either that OR result straight through or a registered copy of it, in true or inverted polarity.

The whole personality of the device sits in one configuration word. That word is loaded one bit per clock through a serial port while the load-enable input is high. Software or a boot sequencer shifts in a full image, drops the enable, and from then on the outputs follow the programmed functions of `din`.

Top module: `sop_logic_array`

## Requirements
- R1: Product term t is the AND of the literals its select bits enable. Configuration bit `t*2*N_IN + 2*i` enables `din[i]`, and bit `t*2*N_IN + 2*i + 1` enables `~din[i]`.
- R2: A product term with no select bit set evaluates to 1. A term that enables both `din[i]` and `~din[i]` evaluates to 0.
- R3: Output k ORs exactly `min(TERMS_MIN + k*TERMS_STEP, TERMS_MAX)` product terms. With the defaults this gives 8, 10, 12, 14 and 16 terms. Output k's group starts right after the terms of outputs 0..k-1, so its last term counts as fully as its first.
- R4: Configuration bit `PLANE_BITS + 2*k + 1` set to 1 inverts output k. Cleared, it leaves output k in true polarity.
- R5: Configuration bit `PLANE_BITS + 2*k` set to 1 selects the registered path: output k shows the OR result captured at the previous rising clock edge. Cleared, it selects the combinational path: output k follows `din` in the same cycle.
- R6: While `cfg_en` is high, each rising edge shifts `cfg_in` into the configuration word. After CFG_W shifts, the bit shifted in first sits at index 0 and the last one at index CFG_W-1.
- R7: While `cfg_en` is low, `cfg_in` has no effect and the configuration word holds its value.
- R8: While `cfg_en` is high, every output reads 0, and the output flip-flops are cleared at each rising edge.
- R9: A synchronous `rst` clears the output flip-flops and leaves the configuration word unchanged. So right after reset a registered output reads its polarity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous reset of the output flip-flops |
| cfg_en | input | 1 | Configuration load enable |
| cfg_in | input | 1 | Serial configuration data |
| din | input | N_IN | Data inputs to the AND plane |
| dout | output | N_OUT | Macrocell outputs |

## Verification
The bench builds the block with its default values: six inputs, five outputs, and term groups of 8 through 16 in steps of 2. A full image is then 730 bits, small enough to load twice in one run. These values put the shortest and the longest OR group side by side, so the bench places terms at the very end of both groups to catch a wrong group offset or size. Six inputs give only 64 input patterns, so both the hand-written image and a sparse random image are swept over every input value against the behavioural model.

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
  parameter int N_IN       = 6,
  parameter int N_OUT      = 5,
  parameter int TERMS_MIN  = 8,
  parameter int TERMS_MAX  = 16,
  parameter int TERMS_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_in,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout
);

  function automatic int terms_of(input int k);
    int t;
    t = TERMS_MIN + k * TERMS_STEP;
    return (t > TERMS_MAX) ? TERMS_MAX : t;
  endfunction

  function automatic int base_of(input int k);
    int s;
    s = 0;
    for (int j = 0; j < k; j++) s += terms_of(j);
    return s;
  endfunction

  localparam int TERM_BITS   = 2 * N_IN;
  localparam int TOTAL_TERMS = base_of(N_OUT);
  localparam int PLANE_BITS  = TOTAL_TERMS * TERM_BITS;
  localparam int CFG_W       = PLANE_BITS + 2 * N_OUT;

  logic [CFG_W-1:0]       cfg;
  logic [TERM_BITS-1:0]   lits;
  logic [TOTAL_TERMS-1:0] term;
  logic [N_OUT-1:0]       sum, q, reg_sel, inv;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = din[i];
    assign lits[2*i+1] = ~din[i];
  end

  for (genvar t = 0; t < TOTAL_TERMS; t++) begin : g_term
    assign term[t] = &(~cfg[t*TERM_BITS +: TERM_BITS] | lits);
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign sum[k]     = |term[base_of(k) +: terms_of(k)];
    assign reg_sel[k] = cfg[PLANE_BITS + 2*k];
    assign inv[k]     = cfg[PLANE_BITS + 2*k + 1];

    // registered path shows the OR result one edge late
    assert_reg_delay_R5: assert property (@(posedge clk) disable iff (rst)
      (!cfg_en && reg_sel[k]) |=> (cfg_en || (dout[k] == ($past(sum[k]) ^ inv[k]))));
  end

  always_ff @(posedge clk) begin
    if (cfg_en) cfg <= {cfg_in, cfg[CFG_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_en) q <= '0;
    else               q <= sum;
  end

  assign dout = cfg_en ? '0 : (((reg_sel & q) | (~reg_sel & sum)) ^ inv);

  assert_shift_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (cfg[CFG_W-1] == $past(cfg_in)) && (cfg[CFG_W-2:0] == $past(cfg[CFG_W-1:1])));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg));

  assert_load_clear_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (q == '0));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (q == '0));

endmodule

// File: tb/test_sop_logic_array.sv
module test_sop_logic_array;
  localparam int NI = 6;
  localparam int NO = 5;
  localparam int TB = 2 * NI;

  function automatic int tcnt(input int k);
    return (8 + 2*k > 16) ? 16 : 8 + 2*k;
  endfunction

  function automatic int tbase(input int k);
    int s;
    s = 0;
    for (int j = 0; j < k; j++) s += tcnt(j);
    return s;
  endfunction

  localparam int PLANE = tbase(NO) * TB;
  localparam int CW    = PLANE + 2 * NO;

  logic clk = 0, rst = 1, cfg_en = 0, cfg_in = 0;
  logic [NI-1:0] din = '0;
  logic [NO-1:0] dout;

  always #2 clk = ~clk;

  sop_logic_array i_sop_logic_array (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in), .din(din), .dout(dout)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit cq[$];
  bit img[CW];
  bit mq[NO];

  task automatic check(input string tag, input int k, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s out%0d din=%0d actual=%b expected=%b", tag, k, din, act, exp);
    end
  endtask

  function automatic bit m_sum(input int k, input logic [NI-1:0] v);
    for (int t = 0; t < tcnt(k); t++) begin
      bit p;
      int b;
      p = 1;
      b = (tbase(k) + t) * TB;
      for (int i = 0; i < NI; i++) begin
        if (cq[b + 2*i] && !v[i]) p = 0;
        if (cq[b + 2*i + 1] && v[i]) p = 0;
      end
      if (p) return 1;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < NO; k++)
      mq[k] = (rst || cfg_en || cq.size() != CW) ? 1'b0 : m_sum(k, din);
    if (cfg_en) begin
      cq.push_back(cfg_in);
      if (cq.size() > CW) void'(cq.pop_front());
    end
  end

  // per-cycle comparison; cfg_in toggles freely while cfg_en is low (R7)
  always @(negedge clk) begin
    if (!done) begin
      if (cfg_en) begin
        for (int k = 0; k < NO; k++) check("R8", k, dout[k], 1'b0);
      end else if (cq.size() == CW) begin
        for (int k = 0; k < NO; k++) begin
          bit e;
          e = cq[PLANE + 2*k] ? mq[k] : m_sum(k, din);
          e = e ^ cq[PLANE + 2*k + 1];
          check(cq[PLANE + 2*k] ? "R5 R7" : "R1 R7", k, dout[k], e);
        end
      end
    end
  end

  task automatic put_term(input int k, input int t, input bit [NI-1:0] tm, input bit [NI-1:0] cm);
    int b;
    b = (tbase(k) + t) * TB;
    for (int i = 0; i < NI; i++) begin
      img[b + 2*i]     = tm[i];
      img[b + 2*i + 1] = cm[i];
    end
  endtask

  // R6: image bit j is shifted in at step j
  task automatic load_image();
    for (int j = 0; j < CW; j++) begin
      @(negedge clk); #1;
      cfg_en = 1;
      cfg_in = img[j];
    end
    @(negedge clk); #1;
    cfg_en = 0;
  endtask

  task automatic hold(input logic [NI-1:0] v);
    @(negedge clk); #1;
    din = v;
    cfg_in = 1'($urandom);
    @(negedge clk);
  endtask

  initial begin
    #600000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;

    // hand-written personality: unused terms conflict on din[0] (R2)
    for (int t = 0; t < tbase(NO); t++) put_term(0, t, 6'b000001, 6'b000001);
    put_term(0, 4, 6'b000001, 6'b000110);
    put_term(0, 5, 6'b000010, 6'b000101);
    put_term(0, 6, 6'b000100, 6'b000011);
    put_term(0, 7, 6'b000111, 6'b000000);
    put_term(1, 0, 6'b000011, 6'b000000);
    put_term(1, 5, 6'b000110, 6'b000000);
    put_term(1, 9, 6'b000101, 6'b000000);
    put_term(2, 10, 6'b000010, 6'b000001);
    put_term(2, 11, 6'b000001, 6'b000010);
    put_term(3, 0, 6'b000000, 6'b000000);
    put_term(4, 15, 6'b110000, 6'b000000);
    img[PLANE+0] = 0; img[PLANE+1] = 0;
    img[PLANE+2] = 0; img[PLANE+3] = 1;
    img[PLANE+4] = 1; img[PLANE+5] = 0;
    img[PLANE+6] = 1; img[PLANE+7] = 1;
    img[PLANE+8] = 0; img[PLANE+9] = 0;
    load_image();

    for (int v = 0; v < 64; v++) begin
      logic [NI-1:0] x;
      logic [1:0] nx;
      x = NI'(v);
      hold(x);
      nx = x[1:0] + 2'd1;
      check("R3 R6", 0, dout[0], ^x[2:0]);
      check("R4", 1, dout[1], ~((x[0] & x[1]) | (x[1] & x[2]) | (x[0] & x[2])));
      check("R5", 2, dout[2], nx[1]);
      check("R2", 3, dout[3], 1'b0);
      check("R3", 4, dout[4], x[5] & x[4]);
    end

    @(negedge clk); #1 rst = 1;
    @(negedge clk);
    check("R9", 3, dout[3], 1'b1);
    check("R9", 2, dout[2], 1'b0);
    #1 rst = 0;
    @(negedge clk);
    check("R9", 3, dout[3], 1'b0);

    // sparse random personality
    for (int j = 0; j < CW; j++) img[j] = (($urandom % 4) == 0);
    load_image();
    for (int v = 0; v < 64; v++) hold(NI'((v * 37) % 64));
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); #1;
      cfg_en = 1;
      cfg_in = 1'($urandom);
    end
    @(negedge clk); #1 cfg_en = 0;
    for (int v = 0; v < 64; v++) hold(NI'((v * 11 + 5) % 64));

    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule